// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This block computes the next program counter of a 32-bit processor for the branch instruction class. Each cycle it may be offered one instruction word whose two top bits are `11`. It also receives the four condition flags (negative, zero, carry, overflow) and the value already read from the register that the instruction names in its low nibble. From these it decides, in the same cycle, whether the branch is taken. It forms the target address, and for a linking branch it requests a write of the return address into register 15. The program counter itself is the only storage. It is loaded at the next rising clock edge.

Two target forms exist. When bit 29 is 0, the target comes from a register and its two low bits are cleared. When bit 29 is 1, a signed 24-bit word offset is added to the address of the following instruction. The branch condition is a 4-bit code. Its low three bits choose one of eight flag predicates, and its top bit inverts the result. In the register form, a non-zero value in bits [7:4] marks a special encoding that some other unit handles. Here such a word is flagged and otherwise treated as falling through.

`ins_valid` qualifies the word on `ins`. The unit applies no back-pressure and has no ready signal: it accepts a valid word in every cycle. When `ins_valid` is low, the program counter holds and every output request is low.

Top module: `branch_link_unit`

## Requirements
- R1: When `rst_n` is low, `pc` is 0. It stays 0 until the first rising edge after `rst_n` rises.
- R2: The condition code `ins[27:24]` selects the predicate as follows. 0 is N, 1 is Z, 2 is C, 3 is V, 4 is C|Z, 5 is N^V, 6 is (N^V)|Z, and 7 is always true.
- R3: Codes 8 to 15 are the logical inverse of codes 0 to 7 in the same order, so code 15 is never taken.
- R4: Register form (`ins[29]`=0, `ins[7:4]`=0000): a taken branch loads `pc` with `rc_val` with bits [1:0] forced to 0.
- R5: Offset form (`ins[29]`=1): a taken branch loads `pc` with `pc` + 4 + 4 × sign-extended `ins[23:0]`, with 32-bit wrap-around.
- R6: For a taken branch with `ins[28]`=1, `link_we` is 1 in the same cycle and `link_data` equals `pc` + 4. The link destination is register 15.
- R7: When the condition is false, `taken` is 0. At the next edge `pc` advances by 4, and `link_we` stays 0 even if `ins[28]`=1.
- R8: Register form with `ins[7:4]` not equal to 0000: `special` is 1, `taken` and `link_we` are 0, and `pc` advances by 4.
- R9: With `ins_valid` low, `pc` keeps its value and `taken`, `link_we` and `special` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Qualifies `ins` for this cycle |
| ins | input | 32 | Branch-class instruction word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| rc_val | input | 32 | Value of the register selected by `ins[3:0]` |
| pc | output | 32 | Registered program counter |
| taken | output | 1 | Branch taken this cycle (combinational) |
| link_we | output | 1 | Write request of `link_data` into register 15 |
| link_data | output | 32 | Return address, `pc` + 4 |
| special | output | 1 | Register-form special encoding seen |

## Verification
Some properties are checked on every cycle by the assertions. Code 15 never hits and code 7 always hits. An idle cycle freezes the counter, and a not-taken or special word advances it by exactly four. No link request appears without a taken branch, and register-form targets land word-aligned. Only the bench's scenarios can show that each of the sixteen codes evaluates the right predicate over chosen flag patterns. The same holds for the exact target values in both forms, including negative and extreme offsets, the return address value, and the reset value.

// File: rtl/brl_pkg.sv
package brl_pkg;

  localparam int COND_W = 4;
  localparam int OFF_W  = 24;
  localparam int NPRED  = 1 << (COND_W - 1);

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic              rel_form;
    logic              link;
    logic [COND_W-1:0] cond;
    logic              is_branch;
    logic              special;
    logic [OFF_W-1:0]  off;
  } dec_t;

endpackage

// File: rtl/brl_decode.sv
module brl_decode
  import brl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            valid,
  input  logic [XLEN-1:0] ins,
  output dec_t            dec
);

  localparam int FORM_BIT = 29;
  localparam int LINK_BIT = 28;
  localparam int COND_LO  = 24;

  logic sub_zero;

  always_comb begin
    sub_zero      = (ins[7:4] == 4'b0000);
    dec.rel_form  = ins[FORM_BIT];
    dec.link      = ins[LINK_BIT];
    dec.cond      = ins[COND_LO +: COND_W];
    dec.off       = ins[OFF_W-1:0];
    dec.is_branch = valid && (ins[FORM_BIT] || sub_zero);
    dec.special   = valid && !ins[FORM_BIT] && !sub_zero;
  end

endmodule

// File: rtl/brl_cond.sv
module brl_cond
  import brl_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  flags_t            flg,
  output logic              hit
);

  logic [NPRED-1:0] base;

  for (genvar i = 0; i < NPRED; i++) begin : g_pred
    always_comb begin
      case (i)
        0:       base[i] = flg.n;
        1:       base[i] = flg.z;
        2:       base[i] = flg.c;
        3:       base[i] = flg.v;
        4:       base[i] = flg.c | flg.z;
        5:       base[i] = flg.n ^ flg.v;
        6:       base[i] = (flg.n ^ flg.v) | flg.z;
        default: base[i] = 1'b1;
      endcase
    end
  end

  assign hit = base[cond[COND_W-2:0]] ^ cond[COND_W-1];

  always_comb begin
    // R3
    if (cond == 4'hF) begin
      never_chk: assert (!hit);
    end
    // R2
    if (cond == 4'h7) begin
      always_chk: assert (hit);
    end
  end

endmodule

// File: rtl/brl_target.sv
module brl_target
  import brl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  pc_cur,
  input  logic [XLEN-1:0]  rc_val,
  input  logic             rel_form,
  input  logic [OFF_W-1:0] off,
  output logic [XLEN-1:0]  seq,
  output logic [XLEN-1:0]  target
);

  localparam int EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] disp;

  always_comb begin
    seq    = pc_cur + XLEN'(4);
    disp   = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    target = rel_form ? (seq + disp) : {rc_val[XLEN-1:2], 2'b00};
  end

endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
  import brl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  input  logic [XLEN-1:0] ins,
  input  logic            flag_n,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic            flag_v,
  input  logic [XLEN-1:0] rc_val,
  output logic [XLEN-1:0] pc,
  output logic            taken,
  output logic            link_we,
  output logic [XLEN-1:0] link_data,
  output logic            special
);

  dec_t            dec;
  flags_t          flg;
  logic            hit;
  logic [XLEN-1:0] seq;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] pc_nxt;

  assign flg = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  brl_decode #(.XLEN(XLEN)) u_dec (
    .valid (ins_valid),
    .ins   (ins),
    .dec   (dec)
  );

  brl_cond u_cond (
    .cond (dec.cond),
    .flg  (flg),
    .hit  (hit)
  );

  brl_target #(.XLEN(XLEN)) u_tgt (
    .pc_cur   (pc),
    .rc_val   (rc_val),
    .rel_form (dec.rel_form),
    .off      (dec.off),
    .seq      (seq),
    .target   (target)
  );

  always_comb begin
    taken     = dec.is_branch && hit;
    link_we   = taken && dec.link;
    link_data = seq;
    special   = dec.special;
    if (!ins_valid)  pc_nxt = pc;
    else if (taken)  pc_nxt = target;
    else             pc_nxt = seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end

  // R7
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !taken) |=> (pc == $past(pc) + XLEN'(4)));

  // R7
  nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !taken) |-> !link_we);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> $stable(pc));

  // R4
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !ins[29]) |=> (pc[1:0] == 2'b00));

  // R8
  special_chk: assert property (@(posedge clk) disable iff (!rst_n)
    special |-> (!taken && !link_we));

endmodule

// File: tb/branch_link_unit_tb.sv
module branch_link_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [31:0] ins = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic [31:0] rc_val = '0;
  logic [31:0] pc;
  logic        taken, link_we, special;
  logic [31:0] link_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] cur_pc = '0;

  always #4 clk = ~clk;

  branch_link_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins(ins),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .rc_val(rc_val), .pc(pc), .taken(taken), .link_we(link_we),
    .link_data(link_data), .special(special)
  );

  // {ins, nzcv, rc_val, expected taken}
  localparam logic [68:0] VEC [18] = '{
    {32'hE0000003, 4'b1000, 32'h00000000, 1'b1},
    {32'hE0000005, 4'b0000, 32'h00000000, 1'b0},
    {32'hD1000007, 4'b0100, 32'h00001237, 1'b1},
    {32'hE2FFFFFE, 4'b0010, 32'h00000000, 1'b1},
    {32'hF3000010, 4'b0000, 32'h00000000, 1'b0},
    {32'hC4000002, 4'b0100, 32'h00004002, 1'b1},
    {32'hE5000001, 4'b1000, 32'h00000000, 1'b1},
    {32'hE5000001, 4'b1001, 32'h00000000, 1'b0},
    {32'hF6000004, 4'b0101, 32'h00000000, 1'b1},
    {32'hE7000000, 4'b0000, 32'h00000000, 1'b1},
    {32'hE8000002, 4'b1000, 32'h00000000, 1'b0},
    {32'hC9000003, 4'b0000, 32'h00000100, 1'b1},
    {32'hEA000002, 4'b0010, 32'h00000000, 1'b0},
    {32'hEB000008, 4'b0000, 32'h00000000, 1'b1},
    {32'hDC000005, 4'b0000, 32'h00002003, 1'b1},
    {32'hED000001, 4'b1001, 32'h00000000, 1'b1},
    {32'hEE000001, 4'b0100, 32'h00000000, 1'b0},
    {32'hFF000001, 4'b1111, 32'h00000000, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] w, input logic [3:0] f,
                         input logic [31:0] rc, input logic exp_t,
                         input logic exp_sp);
    logic [31:0] exp_pc;
    logic        exp_lk;
    string       creq;
    creq = w[27] ? "R3" : "R2";
    ins_valid = 1'b1; ins = w; rc_val = rc;
    {flag_n, flag_z, flag_c, flag_v} = f;
    #1;
    chk(exp_sp ? "R8" : creq, "taken", {31'd0, taken}, {31'd0, exp_t});
    exp_lk = exp_t && w[28];
    chk(exp_lk ? "R6" : "R7", "link_we", {31'd0, link_we}, {31'd0, exp_lk});
    if (exp_lk) chk("R6", "link_data", link_data, cur_pc + 32'd4);
    chk("R8", "special", {31'd0, special}, {31'd0, exp_sp});
    if (!exp_t)      exp_pc = cur_pc + 32'd4;
    else if (w[29])  exp_pc = cur_pc + 32'd4 + {{6{w[23]}}, w[23:0], 2'b00};
    else             exp_pc = {rc[31:2], 2'b00};
    @(negedge clk);
    chk(!exp_t ? "R7" : (w[29] ? "R5" : "R4"), "pc", pc, exp_pc);
    cur_pc = exp_pc;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", pc, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc after release, idle", pc, 32'h0);
    cur_pc = 32'h0;

    for (int i = 0; i < 18; i++) begin
      run_one(VEC[i][68:37], VEC[i][36:33], VEC[i][32:1], VEC[i][0], 1'b0);
    end

    // R8: special register-form encodings, with and without link bit
    run_one(32'hC7000015, 4'b0000, 32'h00008000, 1'b0, 1'b1);
    run_one(32'hD7000025, 4'b1111, 32'h00008000, 1'b0, 1'b1);

    // R4: all-ones register target is cleared to word alignment
    run_one(32'hC7000003, 4'b0000, 32'hFFFFFFFF, 1'b1, 1'b0);

    // R5: most negative offset wraps around
    run_one(32'hE7800000, 4'b0000, 32'h00000000, 1'b1, 1'b0);

    // R9: idle cycle with an always-taken linking word present
    ins_valid = 1'b0; ins = 32'hF7000010;
    #1;
    chk("R9", "taken idle", {31'd0, taken}, 32'd0);
    chk("R9", "link_we idle", {31'd0, link_we}, 32'd0);
    chk("R9", "special idle", {31'd0, special}, 32'd0);
    @(negedge clk);
    chk("R9", "pc held", pc, cur_pc);

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    #1;
    chk("R1", "pc on mid-run reset", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc after second release", pc, 32'h0);

    finish_run();
  end

endmodule